// File: doc/BRIEF.md
# Conditional Relative Branch Execution Unit

This block is the execute stage for the conditional relative branches and the no-operation instruction of an 8-bit accumulator-style microcontroller core. Each accepted transaction carries a decoded opcode, up to two operand bytes, and a snapshot of the machine state the instruction may consult: the program counter, the carry flag, the accumulator, the selected working register, the byte reached through an indirect pointer, the directly addressed byte and the value of the addressed bit. One clock later the block offers the next program counter, whether the branch was taken, the new carry flag, any write-back of a decremented byte or a cleared bit, and the number of machine clock cycles the instruction occupies.

Transactions enter on a valid/ready pair and leave through a single output register on a second valid/ready pair. The input is accepted whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` is low and every output holds its value, so no transaction is lost or duplicated. The write-back flags tell the surrounding core what to update; the target is implied by the opcode (the register number in its low bits) or by operand byte 2 (the direct address).

Top module: `br_exec_unit`

## Requirements
- R1: Opcode 00h advances the program counter by 1, reports 1 cycle, is not taken, leaves carry unchanged and requests no write-back; every opcode outside the forms listed in R2 to R8 behaves identically.
- R2: Opcodes 40h (branch on carry set) and 50h (branch on carry clear) are 2 bytes long, take their offset from byte 2 and report 3 cycles; carry is unchanged.
- R3: Opcodes 20h (branch on bit set) and 30h (branch on bit clear) test `in_bit`, are 3 bytes long, take their offset from byte 3 and report 4 cycles.
- R4: Opcode 10h branches when `in_bit` is 1 and only then raises `out_bit_clr`; it is 3 bytes long, offset in byte 3, and reports 5 cycles when taken and 4 when not.
- R5: The compare-and-branch forms are 3 bytes long with the offset in byte 3: B5h compares the accumulator with the direct byte (5 cycles); B4h compares the accumulator with byte 2 (4 cycles); B8h to BFh compare the working register with byte 2 (4 cycles); B6h and B7h compare the indirect byte with byte 2 (5 cycles).
- R6: A compare-and-branch is taken exactly when its two operands differ; carry becomes 1 when the first operand is below the second (unsigned) and 0 otherwise, including when they are equal.
- R7: Opcodes D8h to DFh decrement the working register, report the result on `out_wb_data` with `out_wb_reg` set, are 2 bytes long with the offset in byte 2, report 3 cycles, and branch when the result is nonzero; 00h decrements to FFh and branches.
- R8: Opcode D5h decrements the direct byte with `out_wb_dir` set, is 3 bytes long with the offset in byte 3, reports 5 cycles and branches when the result is nonzero.
- R9: The next program counter is the current one plus the instruction length, plus the sign-extended 8-bit offset when taken, all modulo 2^16.
- R10: Forms B5h and D5h report one extra cycle when byte 2 names one of the penalised system registers (by default D0h, 81h, 86h, A8h, B8h, E8h, F8h).
- R11: An input is accepted when `in_valid` and `in_ready` are both high; `in_ready` is high exactly when the output register is empty or `out_ready` is high; the result appears on the outputs one cycle after acceptance and holds unchanged while `out_valid` is high and `out_ready` low.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_byte2 | input | 8 | Second instruction byte |
| in_byte3 | input | 8 | Third instruction byte |
| in_pc | input | 16 | Address of the instruction |
| in_carry | input | 1 | Current carry flag |
| in_acc | input | 8 | Accumulator |
| in_reg | input | 8 | Selected working register |
| in_ind | input | 8 | Byte reached through the indirect pointer |
| in_dir | input | 8 | Byte at the direct address in byte 2 |
| in_bit | input | 1 | Value of the addressed bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 16 | Next program counter |
| out_taken | output | 1 | Branch taken |
| out_carry | output | 1 | New carry flag |
| out_wb_reg | output | 1 | Write `out_wb_data` to the working register |
| out_wb_dir | output | 1 | Write `out_wb_data` to the direct byte |
| out_bit_clr | output | 1 | Clear the addressed bit |
| out_wb_data | output | 8 | Decremented value |
| out_cycles | output | 3 | Machine cycles the instruction occupies |

## Verification
The assertions assume the consumer obeys the output handshake only in the sense that the block must not change a pending result; they assume nothing about `in_valid` being held, since an input offered while `in_ready` is low is simply not taken. They also take for granted that the operand snapshot belongs to the opcode on the same cycle, so checks on write-back exclusivity and cycle range rely only on the decoded form. The stimulus presents one transaction at a time with `out_ready` high, and a dedicated stall scenario offers a second transaction while the first is held, so both the accepted and the refused paths of the handshake are driven.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [3:0] {
    F_NOP,
    F_JC,
    F_JNC,
    F_JB,
    F_JNB,
    F_JBC,
    F_CJ_DIR,
    F_CJ_IMM,
    F_CJ_REG,
    F_CJ_IND,
    F_DJ_REG,
    F_DJ_DIR
  } form_e;

  typedef struct packed {
    form_e      form;
    logic [1:0] len;
    logic [2:0] base_cyc;
    logic       dir_byte;
    logic       rel_in_b3;
  } dec_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] opcode,
  output dec_t           dec
);

  always_comb begin
    dec = '{form: F_NOP, len: 2'd1, base_cyc: 3'd1, dir_byte: 1'b0, rel_in_b3: 1'b0};
    casez (opcode)
      8'h40:        dec = '{form: F_JC,     len: 2'd2, base_cyc: 3'd3, dir_byte: 1'b0, rel_in_b3: 1'b0};
      8'h50:        dec = '{form: F_JNC,    len: 2'd2, base_cyc: 3'd3, dir_byte: 1'b0, rel_in_b3: 1'b0};
      8'h20:        dec = '{form: F_JB,     len: 2'd3, base_cyc: 3'd4, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'h30:        dec = '{form: F_JNB,    len: 2'd3, base_cyc: 3'd4, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'h10:        dec = '{form: F_JBC,    len: 2'd3, base_cyc: 3'd4, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'hB5:        dec = '{form: F_CJ_DIR, len: 2'd3, base_cyc: 3'd5, dir_byte: 1'b1, rel_in_b3: 1'b1};
      8'hB4:        dec = '{form: F_CJ_IMM, len: 2'd3, base_cyc: 3'd4, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'b1011_1???: dec = '{form: F_CJ_REG, len: 2'd3, base_cyc: 3'd4, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'b1011_011?: dec = '{form: F_CJ_IND, len: 2'd3, base_cyc: 3'd5, dir_byte: 1'b0, rel_in_b3: 1'b1};
      8'b1101_1???: dec = '{form: F_DJ_REG, len: 2'd2, base_cyc: 3'd3, dir_byte: 1'b0, rel_in_b3: 1'b0};
      8'hD5:        dec = '{form: F_DJ_DIR, len: 2'd3, base_cyc: 3'd5, dir_byte: 1'b1, rel_in_b3: 1'b1};
      default: ;
    endcase
  end

endmodule

// File: rtl/br_penalty.sv
module br_penalty #(
  parameter int               AW        = 8,
  parameter int               N_PEN     = 7,
  parameter logic [N_PEN*AW-1:0] PEN_ADDRS = {8'hD0, 8'h81, 8'h86, 8'hA8, 8'hB8, 8'hE8, 8'hF8}
) (
  input  logic          dir_byte,
  input  logic [AW-1:0] addr,
  output logic          extra
);

  logic [N_PEN-1:0] match;

  for (genvar g = 0; g < N_PEN; g++) begin : g_cmp
    assign match[g] = (addr == PEN_ADDRS[g*AW +: AW]);
  end

  assign extra = dir_byte && (|match);

endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int DW   = 8
) (
  input  dec_t            dec,
  input  logic [DW-1:0]   byte2,
  input  logic [DW-1:0]   byte3,
  input  logic [PC_W-1:0] pc,
  input  logic            carry_in,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   rn,
  input  logic [DW-1:0]   ind,
  input  logic [DW-1:0]   dir,
  input  logic            bit_in,
  output logic            taken,
  output logic            carry_out,
  output logic            wb_reg,
  output logic            wb_dir,
  output logic            bit_clr,
  output logic            jbc_taken,
  output logic [DW-1:0]   wb_data,
  output logic [PC_W-1:0] next_pc
);

  localparam int EXT_W = PC_W - DW;

  logic [DW-1:0]   lhs, rhs, rel, dec_val;
  logic            is_cmp, is_dj;
  logic [PC_W-1:0] seq_pc, offset;

  assign is_cmp = (dec.form == F_CJ_DIR) || (dec.form == F_CJ_IMM) ||
                  (dec.form == F_CJ_REG) || (dec.form == F_CJ_IND);
  assign is_dj  = (dec.form == F_DJ_REG) || (dec.form == F_DJ_DIR);

  always_comb begin
    case (dec.form)
      F_CJ_REG: lhs = rn;
      F_CJ_IND: lhs = ind;
      default:  lhs = acc;
    endcase
    rhs     = (dec.form == F_CJ_DIR) ? dir : byte2;
    dec_val = ((dec.form == F_DJ_DIR) ? dir : rn) - DW'(1);
    rel     = dec.rel_in_b3 ? byte3 : byte2;
  end

  always_comb begin
    case (dec.form)
      F_JC:    taken = carry_in;
      F_JNC:   taken = !carry_in;
      F_JB:    taken = bit_in;
      F_JNB:   taken = !bit_in;
      F_JBC:   taken = bit_in;
      default: begin
        if (is_cmp)     taken = (lhs != rhs);
        else if (is_dj) taken = (dec_val != '0);
        else            taken = 1'b0;
      end
    endcase
  end

  assign carry_out = is_cmp ? (lhs < rhs) : carry_in;
  assign wb_reg    = (dec.form == F_DJ_REG);
  assign wb_dir    = (dec.form == F_DJ_DIR);
  assign jbc_taken = (dec.form == F_JBC) && taken;
  assign bit_clr   = jbc_taken;
  assign wb_data   = dec_val;

  assign seq_pc  = pc + PC_W'(dec.len);
  assign offset  = taken ? {{EXT_W{rel[DW-1]}}, rel} : '0;
  assign next_pc = seq_pc + offset;

endmodule

// File: rtl/br_exec_unit.sv
module br_exec_unit
  import br_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DW    = 8,
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_opcode,
  input  logic [DW-1:0]    in_byte2,
  input  logic [DW-1:0]    in_byte3,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_carry,
  input  logic [DW-1:0]    in_acc,
  input  logic [DW-1:0]    in_reg,
  input  logic [DW-1:0]    in_ind,
  input  logic [DW-1:0]    in_dir,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_next_pc,
  output logic             out_taken,
  output logic             out_carry,
  output logic             out_wb_reg,
  output logic             out_wb_dir,
  output logic             out_bit_clr,
  output logic [DW-1:0]    out_wb_data,
  output logic [CYC_W-1:0] out_cycles
);

  localparam int MAX_CYC = 6;

  dec_t            dec;
  logic            taken, carry_n, wb_reg, wb_dir, bit_clr, jbc_taken, pen;
  logic [DW-1:0]   wb_data;
  logic [PC_W-1:0] next_pc;
  logic [CYC_W-1:0] cycles;
  logic            accept;

  br_decode #(.OPW(DW)) u_dec (
    .opcode (in_opcode),
    .dec    (dec)
  );

  br_penalty #(.AW(DW)) u_pen (
    .dir_byte (dec.dir_byte),
    .addr     (in_byte2),
    .extra    (pen)
  );

  br_resolve #(.PC_W(PC_W), .DW(DW)) u_res (
    .dec       (dec),
    .byte2     (in_byte2),
    .byte3     (in_byte3),
    .pc        (in_pc),
    .carry_in  (in_carry),
    .acc       (in_acc),
    .rn        (in_reg),
    .ind       (in_ind),
    .dir       (in_dir),
    .bit_in    (in_bit),
    .taken     (taken),
    .carry_out (carry_n),
    .wb_reg    (wb_reg),
    .wb_dir    (wb_dir),
    .bit_clr   (bit_clr),
    .jbc_taken (jbc_taken),
    .wb_data   (wb_data),
    .next_pc   (next_pc)
  );

  assign cycles   = CYC_W'(dec.base_cyc) + CYC_W'(pen) + CYC_W'(jbc_taken);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_next_pc <= '0;
      out_taken   <= 1'b0;
      out_carry   <= 1'b0;
      out_wb_reg  <= 1'b0;
      out_wb_dir  <= 1'b0;
      out_bit_clr <= 1'b0;
      out_wb_data <= '0;
      out_cycles  <= '0;
    end else begin
      if (accept) begin
        out_valid   <= 1'b1;
        out_next_pc <= next_pc;
        out_taken   <= taken;
        out_carry   <= carry_n;
        out_wb_reg  <= wb_reg;
        out_wb_dir  <= wb_dir;
        out_bit_clr <= bit_clr;
        out_wb_data <= wb_data;
        out_cycles  <= cycles;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_cycles) && $stable(out_taken) && $stable(out_carry));

  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r4_clr_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bit_clr |-> out_taken);

  a_r8_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_wb_reg, out_wb_dir, out_bit_clr}));

  a_r10_cycle_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cycles != '0) && (out_cycles <= CYC_W'(MAX_CYC)));

endmodule

// File: tb/br_exec_unit_tb.sv
module br_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0, in_byte2 = '0, in_byte3 = '0;
  logic [15:0] in_pc = '0;
  logic        in_carry = 1'b0;
  logic [7:0]  in_acc = '0, in_reg = '0, in_ind = '0, in_dir = '0;
  logic        in_bit = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_next_pc;
  logic        out_taken, out_carry, out_wb_reg, out_wb_dir, out_bit_clr;
  logic [7:0]  out_wb_data;
  logic [2:0]  out_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  br_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_byte2(in_byte2), .in_byte3(in_byte3),
    .in_pc(in_pc), .in_carry(in_carry), .in_acc(in_acc), .in_reg(in_reg),
    .in_ind(in_ind), .in_dir(in_dir), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_next_pc(out_next_pc), .out_taken(out_taken), .out_carry(out_carry),
    .out_wb_reg(out_wb_reg), .out_wb_dir(out_wb_dir), .out_bit_clr(out_bit_clr),
    .out_wb_data(out_wb_data), .out_cycles(out_cycles)
  );

  task automatic chk(input string tag, input logic [15:0] epc, input logic et, input logic ec,
                     input logic [2:0] ecyc, input logic ewr, input logic ewd, input logic eclr,
                     input logic [7:0] ewdata);
    logic [31:0] act, exp;
    act = {out_valid, out_next_pc, out_taken, out_carry, out_cycles, out_wb_reg, out_wb_dir,
           out_bit_clr, ((out_wb_reg | out_wb_dir) ? out_wb_data : 8'h00)};
    exp = {1'b1, epc, et, ec, ecyc, ewr, ewd, eclr, ((ewr | ewd) ? ewdata : 8'h00)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] b2, input logic [7:0] b3,
                     input logic [15:0] pc);
    @(negedge clk);
    in_opcode = op; in_byte2 = b2; in_byte3 = b3; in_pc = pc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 actual=%b%b expected=01", out_valid, in_ready);
    end
  endtask

  task automatic t_nop;
    in_carry = 1'b1;
    run(8'h00, 8'h55, 8'h66, 16'h1234);
    chk("R1 nop", 16'h1235, 0, 1, 3'd1, 0, 0, 0, 8'h00);
    run(8'hA5, 8'h55, 8'h66, 16'h1234);
    chk("R1 other opcode", 16'h1235, 0, 1, 3'd1, 0, 0, 0, 8'h00);
  endtask

  task automatic t_carry_branch;
    in_carry = 1'b1;
    run(8'h40, 8'h10, 8'h77, 16'h1000);
    chk("R2 carry set taken", 16'h1012, 1, 1, 3'd3, 0, 0, 0, 8'h00);
    in_carry = 1'b0;
    run(8'h40, 8'h10, 8'h77, 16'h1000);
    chk("R2 carry set not taken", 16'h1002, 0, 0, 3'd3, 0, 0, 0, 8'h00);
    run(8'h50, 8'hF0, 8'h77, 16'h1000);
    chk("R2 carry clear backward", 16'h0FF2, 1, 0, 3'd3, 0, 0, 0, 8'h00);
  endtask

  task automatic t_bit_branch;
    in_carry = 1'b0;
    in_bit = 1'b1;
    run(8'h20, 8'h33, 8'h05, 16'h2000);
    chk("R3 bit set taken", 16'h2008, 1, 0, 3'd4, 0, 0, 0, 8'h00);
    run(8'h30, 8'h33, 8'h05, 16'h2000);
    chk("R3 bit clear not taken", 16'h2003, 0, 0, 3'd4, 0, 0, 0, 8'h00);
  endtask

  task automatic t_bit_clear;
    in_bit = 1'b1;
    run(8'h10, 8'h33, 8'h02, 16'h2000);
    chk("R4 taken clears", 16'h2005, 1, 0, 3'd5, 0, 0, 1, 8'h00);
    in_bit = 1'b0;
    run(8'h10, 8'h33, 8'h02, 16'h2000);
    chk("R4 not taken keeps", 16'h2003, 0, 0, 3'd4, 0, 0, 0, 8'h00);
  endtask

  task automatic t_compare;
    in_carry = 1'b0;
    in_acc = 8'h30;
    run(8'hB4, 8'h40, 8'h08, 16'h3000);
    chk("R6 acc below imm", 16'h300B, 1, 1, 3'd4, 0, 0, 0, 8'h00);
    run(8'hB4, 8'h20, 8'h08, 16'h3000);
    chk("R6 acc above imm", 16'h300B, 1, 0, 3'd4, 0, 0, 0, 8'h00);
    in_carry = 1'b1;
    run(8'hB4, 8'h30, 8'h08, 16'h3000);
    chk("R6 equal clears carry", 16'h3003, 0, 0, 3'd4, 0, 0, 0, 8'h00);
    in_acc = 8'h10; in_dir = 8'h05;
    run(8'hB5, 8'h30, 8'h08, 16'h3000);
    chk("R5 direct compare", 16'h300B, 1, 0, 3'd5, 0, 0, 0, 8'h00);
    run(8'hB5, 8'hD0, 8'h08, 16'h3000);
    chk("R10 direct compare penalised", 16'h300B, 1, 0, 3'd6, 0, 0, 0, 8'h00);
    in_reg = 8'h7F;
    run(8'hBB, 8'h80, 8'h08, 16'h3000);
    chk("R5 register compare", 16'h300B, 1, 1, 3'd4, 0, 0, 0, 8'h00);
    in_ind = 8'hFF;
    run(8'hB7, 8'h00, 8'h08, 16'h3000);
    chk("R5 indirect compare", 16'h300B, 1, 0, 3'd5, 0, 0, 0, 8'h00);
  endtask

  task automatic t_decrement;
    in_carry = 1'b0;
    in_reg = 8'h01;
    run(8'hDA, 8'hFE, 8'h00, 16'h4000);
    chk("R7 reaches zero", 16'h4002, 0, 0, 3'd3, 1, 0, 0, 8'h00);
    in_reg = 8'h00;
    run(8'hDA, 8'hFE, 8'h00, 16'h4000);
    chk("R7 wraps and branches", 16'h4000, 1, 0, 3'd3, 1, 0, 0, 8'hFF);
    in_dir = 8'h05;
    run(8'hD5, 8'h40, 8'h10, 16'h4000);
    chk("R8 direct decrement", 16'h4013, 1, 0, 3'd5, 0, 1, 0, 8'h04);
    run(8'hD5, 8'h81, 8'h10, 16'h4000);
    chk("R10 direct decrement penalised", 16'h4013, 1, 0, 3'd6, 0, 1, 0, 8'h04);
  endtask

  task automatic t_wrap;
    in_carry = 1'b1;
    run(8'h40, 8'h05, 8'h00, 16'hFFFE);
    chk("R9 forward wrap", 16'h0005, 1, 1, 3'd3, 0, 0, 0, 8'h00);
    in_carry = 1'b0;
    run(8'h50, 8'h80, 8'h00, 16'h0001);
    chk("R9 backward wrap", 16'hFF83, 1, 0, 3'd3, 0, 0, 0, 8'h00);
  endtask

  task automatic t_stall;
    in_carry = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 8'h00; in_pc = 16'h5000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_opcode = 8'h40; in_byte2 = 8'h04; in_pc = 16'h6000; in_carry = 1'b0;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R11 in_ready actual=%b expected=0", in_ready);
    end
    chk("R11 first result shown", 16'h5001, 0, 0, 3'd1, 0, 0, 0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R11 held while stalled", 16'h5001, 0, 0, 3'd1, 0, 0, 0, 8'h00);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result after release", 16'h6002, 0, 0, 3'd3, 0, 0, 0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 drain actual=%b expected=0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_nop();
    t_carry_branch();
    t_bit_branch();
    t_bit_clear();
    t_compare();
    t_decrement();
    t_wrap();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule